// File: doc/BRIEF.md
# Multiplexed GPIO Port Register Bank

This block is the register file and pad-control logic for one 16-pin general-purpose I/O port. Software reaches it over a plain 32-bit register bus with a word address, a write strobe, write data and combinational read data. Per pin it keeps a direction/function mode, an output driver type, a speed grade, a pull bias and a 4-bit alternate-function index. It also keeps an output latch and an input sample register.

A write-only set/clear port lets software raise or drop individual output bits in one bus write, with no read-modify-write. The pad/mux layer sees per-pin signals from the block: output level, output enable, open-drain select, pull select and alternate-function index. External pin levels pass through a two-stage synchronizer before software can read them.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is active and after it is released, every writable register reads 0, so all pins are inputs with no pull: `pad_oe`, `pad_pull` and `pad_af` are 0.
- R2: The mode word (byte address 0x00) holds 2 bits per pin at bit 2·n. Encodings: 00 input, 01 general output, 10 alternate function, 11 analog. `pad_oe[n]` can be 1 only for codes 01 and 10.
- R3: Alternate-function indices are 4 bits per pin. Pins 0–7 sit at bit 4·(n mod 8) of the word at 0x20, pins 8–15 at the same positions of the word at 0x24. `pad_af[4n+3:4n]` carries pin n's index.
- R4: Writing the set/clear word (0x18) with bit n = 1 (n in 0–15) sets output bit n; bit n+16 = 1 clears output bit n; output bits with neither bit set keep their value.
- R5: When one write to 0x18 has both bit n and bit n+16 set, output bit n becomes 1.
- R6: Reads of the set/clear word (0x18) return 0.
- R7: Input word (0x10) bit n returns pin n's level after two clock edges of synchronization; bits 31:16 read 0.
- R8: The driver-type word (0x04) holds 1 bit per pin: 0 push-pull, 1 open-drain, mirrored on `pad_od`. An open-drain pin in an output-capable mode drives only when its output bit is 0.
- R9: The pull word (0x0C) holds 2 bits per pin at bit 2·n (00 none, 01 pull-up, 10 pull-down), read back and driven on `pad_pull`.
- R10: The speed word (0x08) holds 2 bits per pin at bit 2·n and reads back as written.
- R11: The output word (0x14) is writable directly in bits 15:0, drives `pad_out`, and reads 0 in bits 31:16.
- R12: Writes to the input word (0x10) and to the reserved word at 0x1C change nothing, and 0x1C reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Per-pin output level |
| pad_oe | output | 16 | Per-pin output enable |
| pad_od | output | 16 | Per-pin open-drain select |
| pad_pull | output | 32 | Per-pin 2-bit pull select |
| pad_af | output | 64 | Per-pin 4-bit alternate-function index |

## Verification
The hardest case to reach is an open-drain output whose enable has to follow its own output bit. The pin must be in an output-capable mode with open-drain type, and the set/clear word must then move that same bit both ways. The vector table builds this up in order: first the modes, then the driver type, then set/clear writes that include the set-and-clear collision on one pin. The bench checks `pad_oe` after each step. The synchronizer latency is checked separately by changing the pins and reading the input word at each of the next two edges.

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [15:0]   pin_in,
  output logic [15:0]   pad_out,
  output logic [15:0]   pad_oe,
  output logic [15:0]   pad_od,
  output logic [31:0]   pad_pull,
  output logic [63:0]   pad_af
);
  localparam int PINS = 16;
  localparam logic [3:0] A_MODE = 4'd0, A_TYPE = 4'd1, A_SPEED = 4'd2, A_PULL = 4'd3,
                         A_IN = 4'd4, A_OUT = 4'd5, A_SETCLR = 4'd6, A_AFLO = 4'd8,
                         A_AFHI = 4'd9;

  logic [2*PINS-1:0] mode_q, speed_q, pull_q;
  logic [PINS-1:0]   type_q, out_q, sync1_q, sync2_q;
  logic [31:0]       aflo_q, afhi_q;
  logic [3:0]        idx;

  assign idx = bus_addr[5:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      type_q  <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      out_q   <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
    end else if (bus_we) begin
      case (idx)
        A_MODE:   mode_q  <= bus_wdata;
        A_TYPE:   type_q  <= bus_wdata[PINS-1:0];
        A_SPEED:  speed_q <= bus_wdata;
        A_PULL:   pull_q  <= bus_wdata;
        A_OUT:    out_q   <= bus_wdata[PINS-1:0];
        A_SETCLR: out_q   <= (out_q & ~bus_wdata[31:16]) | bus_wdata[15:0];
        A_AFLO:   aflo_q  <= bus_wdata;
        A_AFHI:   afhi_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (idx)
      A_MODE:  bus_rdata = mode_q;
      A_TYPE:  bus_rdata = {16'h0, type_q};
      A_SPEED: bus_rdata = speed_q;
      A_PULL:  bus_rdata = pull_q;
      A_IN:    bus_rdata = {16'h0, sync2_q};
      A_OUT:   bus_rdata = {16'h0, out_q};
      A_AFLO:  bus_rdata = aflo_q;
      A_AFHI:  bus_rdata = afhi_q;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic drive_mode;
    assign drive_mode = mode_q[2*i+1] ^ mode_q[2*i];
    assign pad_oe[i]  = drive_mode & (~type_q[i] | ~out_q[i]);
  end

  assign pad_out  = out_q;
  assign pad_od   = type_q;
  assign pad_pull = pull_q;
  assign pad_af   = {afhi_q, aflo_q};
endmodule

module gpio_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [15:0] pin_in,
  input logic [15:0] pad_out,
  input logic [15:0] pad_oe,
  input logic [15:0] pad_od,
  input logic [31:0] pad_pull,
  input logic [63:0] pad_af
);
  logic [1:0] cyc;
  logic       sc_wr;
  assign sc_wr = bus_we && bus_addr[5:2] == 4'd6;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;

  always @(posedge clk)
    if (!rst_n) p_reset_idle_r1: assert (pad_oe == '0 && pad_pull == '0 && pad_af == '0);

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> (pad_out & ~$past(bus_wdata[15:0] | bus_wdata[31:16])) ==
              ($past(pad_out) & ~$past(bus_wdata[15:0] | bus_wdata[31:16])));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> (pad_out & $past(bus_wdata[31:16] & ~bus_wdata[15:0])) == '0);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> (pad_out & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0]));
  p_setclr_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[5:2] == 4'd6 |-> bus_rdata == '0);
  p_sync_two_edges_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && bus_addr[5:2] == 4'd4) |-> bus_rdata == {16'h0, $past(pin_in, 2)});
  p_od_no_high_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_od & pad_out) == '0);
  p_reserved_reads_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[5:2] == 4'd7 |-> bus_rdata == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk u_chk (.*);

// File: tb/tb_gpio_port_regs.sv
`timescale 1ns/1ps
module tb_gpio_port_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pad_out, pad_oe, pad_od;
  logic [31:0] pad_pull;
  logic [63:0] pad_af;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_port_regs dut (.*);

  typedef struct packed {
    logic [5:0]  wa;
    logic [31:0] wd;
    logic [5:0]  ra;
    logic [31:0] er;
    logic [15:0] eo;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{6'h00, 32'h0000_0005, 6'h00, 32'h0000_0005, 16'h0003, 4'd2},  // R2 pins 0,1 output
    '{6'h00, 32'h0000_00E5, 6'h00, 32'h0000_00E5, 16'h0007, 4'd2},  // R2 pin2 alt, pin3 analog
    '{6'h04, 32'h0000_0001, 6'h04, 32'h0000_0001, 16'h0007, 4'd8},  // R8 pin0 open-drain, out 0
    '{6'h18, 32'h0000_0003, 6'h14, 32'h0000_0003, 16'h0006, 4'd4},  // R4 set 0,1; R8 pin0 released
    '{6'h18, 32'h0002_0010, 6'h14, 32'h0000_0011, 16'h0006, 4'd4},  // R4 clear 1, set 4
    '{6'h18, 32'h0001_0001, 6'h14, 32'h0000_0011, 16'h0006, 4'd5},  // R5 collision on pin0
    '{6'h20, 32'h0000_0700, 6'h20, 32'h0000_0700, 16'h0006, 4'd3},  // R3 pin2 index 7
    '{6'h24, 32'hA000_0000, 6'h24, 32'hA000_0000, 16'h0006, 4'd3},  // R3 pin15 index A
    '{6'h0C, 32'h0000_0009, 6'h0C, 32'h0000_0009, 16'h0006, 4'd9},  // R9 pin0 up, pin1 down
    '{6'h08, 32'hFFFF_0003, 6'h08, 32'hFFFF_0003, 16'h0006, 4'd10}, // R10 speed readback
    '{6'h14, 32'hFFFF_8000, 6'h14, 32'h0000_8000, 16'h0007, 4'd11}, // R11 direct output write
    '{6'h1C, 32'hFFFF_FFFF, 6'h1C, 32'h0000_0000, 16'h0007, 4'd12}, // R12 reserved word
    '{6'h10, 32'hFFFF_FFFF, 6'h10, 32'h0000_0000, 16'h0007, 4'd12}, // R12 input word not writable
    '{6'h18, 32'h0000_0000, 6'h18, 32'h0000_0000, 16'h0007, 4'd6}   // R6 set/clear reads 0
  };

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk({32'h0, bus_rdata}, {32'h0, exp}, req, "read data");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({48'h0, pad_oe}, 64'h0, "R1", "pad_oe in reset");
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 10; a++) rd(6'(a * 4), 32'h0, "R1");
    chk({32'h0, pad_pull}, 64'h0, "R1", "pad_pull");
    chk(pad_af, 64'h0, "R1", "pad_af");
    chk({48'h0, pad_oe}, 64'h0, "R1", "pad_oe");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, VEC[i].er, $sformatf("R%0d", VEC[i].rq));
      chk({48'h0, pad_oe}, {48'h0, VEC[i].eo}, $sformatf("R%0d", VEC[i].rq), "pad_oe");
    end

    chk(pad_af, 64'hA000_0000_0000_0700, "R3", "pad_af");
    chk({32'h0, pad_pull}, 64'h9, "R9", "pad_pull");
    chk({48'h0, pad_od}, 64'h1, "R8", "pad_od");
    chk({48'h0, pad_out}, 64'h8000, "R11", "pad_out");
    rd(6'h14, 32'h0000_8000, "R12");

    // R7 two-edge input latency
    @(negedge clk);
    pin_in = 16'hA5A5;
    rd(6'h10, 32'h0, "R7");
    @(negedge clk);
    rd(6'h10, 32'h0, "R7");
    @(negedge clk);
    rd(6'h10, 32'h0000_A5A5, "R7");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    chk({48'h0, pad_oe}, 64'h0, "R1", "pad_oe after reset");
    rd(6'h00, 32'h0, "R1");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(6'h14, 32'h0, "R1");
    finish_run();
  end
endmodule